// File: doc/BRIEF.md
# Excluded-tag random tag selector

This block hands out a 4-bit allocation tag each time a request is accepted. Each request carries a 16-bit exclusion mask, with one bit per tag value. A set bit forbids that tag. The request also carries a mode bit and an optional caller-supplied starting tag. The resulting tag is presented with a valid flag and is held steady until the next request is accepted.

Mode 0 is the debug path. It takes a draw from a loadable pseudo-random shift register, or uses the caller's start value. It then walks upward, modulo 16, to the first tag the mask allows. The result appears one cycle after acceptance. Mode 1 aims for a flat distribution over the allowed tags. It draws from a second, independent shift register and, once per cycle, discards draws that are excluded. It gives up after a bounded number of tries and then falls back to the upward walk. A mask that forbids all sixteen tags always yields tag 0.

Top module: `tagpick_top`

## Requirements
- R1: After reset, `req_ready` is 1, `tag_valid` is 0 and `tag` is 0.
- R2: Bit i of `req_mask` set forbids tag i. While `tag_valid` is 1, `tag` is never a tag forbidden by the mask of the accepted request, unless that mask is all ones.
- R3: If all 16 mask bits are set, the output tag is 0 in both modes. In mode 1 this result is given in the cycle after acceptance, with no redraw.
- R4: In mode 0 without a start value, the draw is bits [3:0] of generator A's current state, and A then advances one step. Generator A is 16 bits wide, shifts left, and takes as its new bit 0 the XOR of state bits 15, 13, 12 and 10. Its reset state is 16'hACE1. `tag_valid` is 1 in the cycle after acceptance.
- R5: The allowed-tag search starts at the draw, steps by +1 modulo 16, and returns the first tag whose mask bit is clear.
- R6: In mode 0 with `req_use_start` = 1, the draw is `req_start` and generator A does not advance.
- R7: In mode 1, on each cycle after acceptance, bits [3:0] of generator B are taken as a candidate and B advances one step. Generator B shifts left and takes as its new bit 0 the XOR of bits 15, 14, 12 and 3. Its reset state is 16'h1D2B. The first candidate that is not excluded becomes the tag, with `tag_valid` rising on that cycle, so the result arrives k+1 cycles after acceptance when the k-th candidate is used.
- R8: If the 16th candidate in mode 1 is still excluded, the tag is the search result (R5) starting at that candidate. `req_start` has no effect in mode 1.
- R9: `req_ready` is 0 while a mode-1 draw is in progress. Once `tag_valid` is 1, it stays 1 and `tag` stays unchanged until the next accepted request.
- R10: A pulse on `seed_load` writes `seed_value` into generator A (`seed_sel` = 0) or B (`seed_sel` = 1). A zero value is ignored. A load takes priority over a step in the same cycle, and the draw in that cycle uses the state from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 1 | 0: debug draw with search, 1: uniform redraw |
| req_mask | input | 16 | Exclusion mask, bit i forbids tag i |
| req_use_start | input | 1 | Mode 0 only: use req_start as the draw |
| req_start | input | 4 | Caller-supplied starting tag |
| seed_load | input | 1 | Load a generator state this cycle |
| seed_sel | input | 1 | 0: generator A, 1: generator B |
| seed_value | input | 16 | New generator state (zero ignored) |
| tag_valid | output | 1 | Tag output is valid |
| tag | output | 4 | Selected allocation tag |

## Verification
A generator reload and a request that steps the same generator can land on the same clock edge. The bench provokes this in two ways. First, it raises `seed_load` together with an accepted mode-0 request. Second, it reloads generator B while a mode-1 redraw is in progress. The tag is judged against a model in which the draw comes from the state before the load. The model then continues from the loaded seed, so every later tag also shows whether the load won over the step. A zero-valued load is judged the same way, against a model that left the generator untouched.

// File: rtl/tagpick_pkg.sv
package tagpick_pkg;
   typedef enum logic [0:0] {
      TP_IDLE = 1'b0,
      TP_DRAW = 1'b1
   } tp_state_e;
endpackage

// File: rtl/tagpick_lfsr.sv
module tagpick_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] state
);
   if (W < 2)     $error("tagpick_lfsr: W must be at least 2");
   if (SEED == '0) $error("tagpick_lfsr: SEED must be nonzero");

   logic [W-1:0] nxt;
   assign nxt = {state[W-2:0], ^(state & TAPS)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (load && (load_val != '0)) begin
         state <= load_val;
      end else if (step) begin
         state <= nxt;
      end
   end
endmodule

// File: rtl/tagpick_scan.sv
module tagpick_scan #(
   parameter int TAG_W = 4,
   localparam int NTAGS = 1 << TAG_W
) (
   input  logic [TAG_W-1:0] start,
   input  logic [NTAGS-1:0] mask,
   output logic [TAG_W-1:0] pick
);
   // Walk downward so the nearest allowed offset from start is assigned last.
   always_comb begin
      pick = '0;
      for (int i = NTAGS - 1; i >= 0; i--) begin
         if (!mask[start + TAG_W'(i)]) pick = start + TAG_W'(i);
      end
   end
endmodule

// File: rtl/tagpick_top.sv
module tagpick_top #(
   parameter int              TAG_W     = 4,
   parameter int              LFSR_W    = 16,
   parameter int              MAX_TRIES = 16,
   parameter logic [LFSR_W-1:0] TAPS_A  = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED_A  = 16'hACE1,
   parameter logic [LFSR_W-1:0] TAPS_B  = 16'hD008,
   parameter logic [LFSR_W-1:0] SEED_B  = 16'h1D2B,
   localparam int             NTAGS     = 1 << TAG_W,
   localparam int             TRY_W     = $clog2(MAX_TRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_mode,
   input  logic [NTAGS-1:0]  req_mask,
   input  logic              req_use_start,
   input  logic [TAG_W-1:0]  req_start,
   input  logic              seed_load,
   input  logic              seed_sel,
   input  logic [LFSR_W-1:0] seed_value,
   output logic              tag_valid,
   output logic [TAG_W-1:0]  tag
);
   import tagpick_pkg::*;

   if (LFSR_W < TAG_W) $error("tagpick_top: LFSR_W must cover TAG_W");
   if (MAX_TRIES < 1)  $error("tagpick_top: MAX_TRIES must be positive");

   tp_state_e         state;
   logic [NTAGS-1:0]  mask_q;
   logic [TRY_W-1:0]  tries;
   logic [TAG_W-1:0]  tag_q;
   logic              tvalid_q;
   logic [LFSR_W-1:0] gen_a_state;
   logic [LFSR_W-1:0] gen_b_state;
   logic [TAG_W-1:0]  scan_start;
   logic [NTAGS-1:0]  scan_mask;
   logic [TAG_W-1:0]  scan_pick;
   logic [TAG_W-1:0]  draw_a;
   logic [TAG_W-1:0]  draw_b;
   logic              accept;
   logic              all_out;
   logic              in_draw;

   assign in_draw   = (state == TP_DRAW);
   assign req_ready = !in_draw;
   assign accept    = req_valid && req_ready;
   assign all_out   = &req_mask;
   assign draw_a    = req_use_start ? req_start : gen_a_state[TAG_W-1:0];
   assign draw_b    = gen_b_state[TAG_W-1:0];

   tagpick_lfsr #(.W(LFSR_W), .TAPS(TAPS_A), .SEED(SEED_A)) u_gen_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (accept && !req_mode && !req_use_start),
      .load     (seed_load && !seed_sel),
      .load_val (seed_value),
      .state    (gen_a_state)
   );

   tagpick_lfsr #(.W(LFSR_W), .TAPS(TAPS_B), .SEED(SEED_B)) u_gen_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (in_draw),
      .load     (seed_load && seed_sel),
      .load_val (seed_value),
      .state    (gen_b_state)
   );

   // One search unit serves both the mode-0 path and the mode-1 fallback.
   assign scan_start = in_draw ? draw_b : draw_a;
   assign scan_mask  = in_draw ? mask_q : req_mask;

   tagpick_scan #(.TAG_W(TAG_W)) u_scan (
      .start (scan_start),
      .mask  (scan_mask),
      .pick  (scan_pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TP_IDLE;
         mask_q   <= '0;
         tries    <= '0;
         tag_q    <= '0;
         tvalid_q <= 1'b0;
      end else if (!in_draw) begin
         if (accept) begin
            mask_q <= req_mask;
            tries  <= '0;
            if (req_mode && !all_out) begin
               state    <= TP_DRAW;
               tvalid_q <= 1'b0;
            end else begin
               tag_q    <= scan_pick;
               tvalid_q <= 1'b1;
            end
         end
      end else begin
         if (!mask_q[draw_b]) begin
            tag_q    <= draw_b;
            tvalid_q <= 1'b1;
            state    <= TP_IDLE;
         end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
            tag_q    <= scan_pick;
            tvalid_q <= 1'b1;
            state    <= TP_IDLE;
         end else begin
            tries <= tries + 1'b1;
         end
      end
   end

   assign tag       = tag_q;
   assign tag_valid = tvalid_q;
endmodule

// File: rtl/tagpick_chk.sv
module tagpick_chk #(
   parameter int  TAG_W     = 4,
   parameter int  LFSR_W    = 16,
   parameter int  MAX_TRIES = 16,
   localparam int NTAGS     = 1 << TAG_W,
   localparam int CNT_W     = $clog2(MAX_TRIES + 2) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_mode,
   input logic [NTAGS-1:0]  req_mask,
   input logic              tag_valid,
   input logic [TAG_W-1:0]  tag,
   input logic [LFSR_W-1:0] gen_a_state,
   input logic [LFSR_W-1:0] gen_b_state
);
   logic             acc;
   logic [NTAGS-1:0] mask_seen;
   logic [CNT_W-1:0] busy_cnt;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_seen <= '0;
         busy_cnt  <= '0;
      end else begin
         if (acc) mask_seen <= req_mask;
         busy_cnt <= req_ready ? '0 : busy_cnt + 1'b1;
      end
   end

   assert_tag_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_valid && !(&mask_seen)) |-> !mask_seen[tag]);

   assert_all_out_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_valid && (&mask_seen)) |-> (tag == '0));

   assert_mode0_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_mode) |=> tag_valid);

   assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CNT_W'(MAX_TRIES));

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_mode && !(&req_mask)) |=> (!req_ready && !tag_valid));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_valid && !acc) |=> (tag_valid && $stable(tag)));

   assert_gen_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_a_state != '0) && (gen_b_state != '0));
endmodule

bind tagpick_top tagpick_chk #(
   .TAG_W     (TAG_W),
   .LFSR_W    (LFSR_W),
   .MAX_TRIES (MAX_TRIES)
) u_tagpick_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_mode    (req_mode),
   .req_mask    (req_mask),
   .tag_valid   (tag_valid),
   .tag         (tag),
   .gen_a_state (gen_a_state),
   .gen_b_state (gen_b_state)
);

// File: tb/tagpick_top_bench.sv
module tagpick_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_mode = 1'b0;
   logic [15:0] req_mask = '0;
   logic        req_use_start = 1'b0;
   logic [3:0]  req_start = '0;
   logic        seed_load = 1'b0;
   logic        seed_sel = 1'b0;
   logic [15:0] seed_value = '0;
   logic        tag_valid;
   logic [3:0]  tag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] ma = 16'hACE1;
   logic [15:0] mb = 16'h1D2B;

   always #4 clk = ~clk;

   tagpick_top u_tagpick_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_mask(req_mask), .req_use_start(req_use_start),
      .req_start(req_start), .seed_load(seed_load), .seed_sel(seed_sel),
      .seed_value(seed_value), .tag_valid(tag_valid), .tag(tag)
   );

   // {mask, start, expected tag}, mode 0 with caller start
   localparam logic [23:0] VEC [8] = '{
      {16'h0000, 4'h7, 4'h7},
      {16'h0080, 4'h7, 4'h8},
      {16'h8000, 4'hF, 4'h0},
      {16'h7FFF, 4'h3, 4'hF},
      {16'hFFFE, 4'h9, 4'h0},
      {16'hFFFF, 4'h5, 4'h0},
      {16'h00F0, 4'h5, 4'h8},
      {16'hAAAA, 4'h1, 4'h2}
   };

   function automatic logic [15:0] nx_a(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic logic [15:0] nx_b(logic [15:0] s);
      return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
   endfunction

   function automatic logic [3:0] search(logic [3:0] st, logic [15:0] m);
      for (int i = 0; i < 16; i++) begin
         if (!m[4'(st + 4'(i))]) return 4'(st + 4'(i));
      end
      return 4'h0;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issue one request; optionally a seed load in the same cycle.
   // Returns the cycle count from acceptance to tag_valid.
   task automatic issue(input bit mode, input logic [15:0] mask, input bit us,
                        input logic [3:0] st, input bit ld, input bit lsel,
                        input logic [15:0] lval, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_mode = mode; req_mask = mask;
      req_use_start = us; req_start = st;
      seed_load = ld; seed_sel = lsel; seed_value = lval;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; seed_load = 1'b0;
      lat = 1;
      while (!tag_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
   endtask

   // Model of one request. Returns expected tag and latency.
   task automatic model(input bit mode, input logic [15:0] mask, input bit us,
                        input logic [3:0] st, input bit ld, input bit lsel,
                        input logic [15:0] lval, output logic [3:0] e,
                        output int elat);
      logic [3:0] c;
      if (!mode) begin
         c = us ? st : ma[3:0];
         if (ld && !lsel && lval != 0) ma = lval;
         else if (!us) ma = nx_a(ma);
         if (ld && lsel && lval != 0) mb = lval;
         e = search(c, mask);
         elat = 1;
      end else begin
         if (ld && lval != 0) begin
            if (lsel) mb = lval; else ma = lval;
         end
         e = 4'h0; elat = 1;
         if (!(&mask)) begin
            for (int i = 0; i < 16; i++) begin
               c = mb[3:0];
               mb = nx_b(mb);
               elat = i + 2;
               if (!mask[c]) begin e = c; break; end
               if (i == 15) e = search(c, mask);
            end
         end
      end
   endtask

   task automatic run(input bit mode, input logic [15:0] mask, input bit us,
                      input logic [3:0] st, input string req);
      logic [3:0] e; int el; int al;
      model(mode, mask, us, st, 1'b0, 1'b0, 16'h0, e, el);
      issue(mode, mask, us, st, 1'b0, 1'b0, 16'h0, al);
      chk(tag_valid && tag == e, req, tag, e);
      chk(al == el, {req, " latency"}, al, el);
   endtask

   initial begin
      logic [3:0] e; int el; int al;
      logic [15:0] m;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk(tag_valid == 1'b0, "R1 valid", tag_valid, 0);
      chk(tag == 4'h0, "R1 tag", tag, 0);
      rst_n = 1'b1;

      // Table: R5 search and R6 caller start (generator A untouched), R3 all ones
      for (int k = 0; k < 8; k++) begin
         issue(1'b0, VEC[k][23:8], 1'b1, VEC[k][7:4], 1'b0, 1'b0, 16'h0, al);
         chk(tag == VEC[k][3:0], "R5 R6 table", tag, VEC[k][3:0]);
      end

      // R4 mode 0 draws from generator A, R2 never excluded
      for (int k = 0; k < 10; k++) begin
         m = 16'h1111 << (k % 4);
         run(1'b0, (k < 3) ? 16'h0000 : m, 1'b0, 4'h0, "R4 R2 mode0");
      end

      // R9 hold: tag stays while idle
      e = tag;
      repeat (4) @(negedge clk);
      chk(tag_valid && tag == e, "R9 hold", tag, e);

      // R7 mode 1 redraw with several masks, R8 start ignored
      for (int k = 0; k < 8; k++) begin
         m = (k < 4) ? (16'h00FF << k) : 16'hFFFF & ~(16'h1 << (k * 3));
         run(1'b1, m, 1'b1, 4'hC, "R7 R8 mode1");
      end
      // R8 fallback likely with a single allowed tag; model covers both outcomes
      for (int k = 0; k < 4; k++) run(1'b1, 16'hFFFF & ~(16'h1 << (k + 5)), 1'b0, 4'h0, "R8 single allowed");

      // R3 all excluded in mode 1: tag 0 next cycle
      run(1'b1, 16'hFFFF, 1'b0, 4'h0, "R3 mode1 all ones");

      // R9 not ready during mode-1 draw
      @(negedge clk);
      req_valid = 1'b1; req_mode = 1'b1; req_mask = 16'h0FFF; req_use_start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !tag_valid, "R9 busy", req_ready, 0);
      model(1'b1, 16'h0FFF, 1'b0, 4'h0, 1'b0, 1'b0, 16'h0, e, el);
      al = 1;
      while (!tag_valid && al < 40) begin @(negedge clk); al++; end
      chk(tag == e, "R9 busy result", tag, e);

      // R10 seed load with a same-cycle mode-0 request: draw from old state
      model(1'b0, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b0, 16'h5A37, e, el);
      issue(1'b0, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b0, 16'h5A37, al);
      chk(tag == e, "R10 load with step", tag, e);
      run(1'b0, 16'h0000, 1'b0, 4'h0, "R10 after load");
      run(1'b0, 16'h0000, 1'b0, 4'h0, "R10 after load 2");

      // R10 zero load ignored
      @(negedge clk);
      seed_load = 1'b1; seed_sel = 1'b0; seed_value = 16'h0;
      @(negedge clk);
      seed_load = 1'b0;
      run(1'b0, 16'h0000, 1'b0, 4'h0, "R10 zero ignored");

      // R10 load of generator B during a mode-1 draw
      @(negedge clk);
      req_valid = 1'b1; req_mode = 1'b1; req_mask = 16'hFFFE; req_use_start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      // first draw cycle uses mb, and the load overrides the step
      e = 4'h0;
      if (mb[3:0] == 4'h0) begin
         seed_load = 1'b0;
         mb = nx_b(mb);
      end else begin
         seed_load = 1'b1; seed_sel = 1'b1; seed_value = 16'h7770;
         mb = 16'h7770;
         begin
            int i;
            for (i = 1; i < 16; i++) begin
               if (mb[3:0] == 4'h0) begin mb = nx_b(mb); break; end
               mb = nx_b(mb);
            end
         end
      end
      @(negedge clk);
      seed_load = 1'b0;
      al = 1;
      while (!tag_valid && al < 40) begin @(negedge clk); al++; end
      chk(tag == e, "R10 load during draw", tag, e);
      run(1'b1, 16'h00FF, 1'b0, 4'h0, "R10 B after load");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule